// File: doc/BRIEF.md
# Multicore Common Interrupt Distributor

This block takes a set of shared interrupt lines and fans them out to the interrupt inputs of several cores. Software programs it through a single-cycle command port. A command carries an opcode, an interrupt index and a 32-bit data word. Read commands return their result on a registered 32-bit readback port. Each shared interrupt has four pieces of state: a destination mask with one bit per core, a packed mode word, a mask bit and an edge latch. A single global switch gates all delivery.

In direct mode an active interrupt is raised on every core named in its destination mask. In rotating mode it is raised on exactly one of those cores. A per-interrupt pointer chooses that core and moves on to the next core in the mask each time the interrupt is acknowledged, so successive events are spread over the set. Each line is either level sensitive (active high) or rising-edge sensitive. An edge is held in a latch until an acknowledge clears it. Software changes one field of the mode word by reading the whole word, editing it and writing it back.

Top module: `common_irq_distributor`

## Requirements
- R1: After reset every core output is low and the readback is zero. Every interrupt is masked, with destination mask zero, mode word zero (direct, level) and rotation pointer at core 0. Delivery is off.
- R2: Opcodes on `cmdOp`: 0 no operation, 1 set destination, 2 set mode, 3 read mode, 4 set mask, 5 acknowledge, 6 enable delivery, 7 read destination. A read command loads `readback` at the clock edge that accepts it, with the destination mask zero-extended for opcode 7. `readback` holds its value until the next read command.
- R3: The mode word holds the distribution mode in bits [1:0] (0 direct, 1 rotating) and the trigger type in bit 4 (0 level, 1 rising edge). Reading it returns all other bits as zero, so a write of all ones reads back as 0x13.
- R4: No core output goes high until an enable-delivery command has been accepted, whatever the interrupt inputs and configuration.
- R5: In direct mode an active, unmasked interrupt drives every core in its destination mask and no other core.
- R6: A level interrupt is active while its input is high and inactive once the input is low. An acknowledge does not change its delivery.
- R7: An edge interrupt latches a rising edge of its input and stays active after the input falls, until an acknowledge for that index clears it.
- R8: Set-mask with data bit 0 equal to 1 masks the interrupt and with 0 unmasks it. A masked interrupt drives no core, but its edge latch is kept and shows again when it is unmasked.
- R9: In rotating mode the interrupt drives only the first destination core at or after the pointer, searching upward and wrapping. Each acknowledge moves the pointer to the core just past the selected one, modulo the core count.
- R10: In rotating mode the selected core does not change while an edge interrupt waits for its acknowledge, even after the input has fallen.
- R11: The output of a core is the OR of all interrupts currently routed to that core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, one command per cycle |
| cmdOp | input | 4 | Command opcode |
| cmdIdx | input | IDX_W | Index of the shared interrupt addressed |
| cmdData | input | 32 | Command data word |
| readback | output | 32 | Result of the last read command |
| irqIn | input | NUM_IRQ | Shared interrupt inputs |
| coreIrq | output | NUM_CORE | Interrupt lines to the cores |

## Verification
The bench builds the block with four shared interrupts and four cores. A four-bit destination mask makes room for a rotating set of three cores with a gap, {0,1,3}. With that set the pointer has to skip core 2 and then wrap from core 3 back to core 0. Four lines are also enough to run a level interrupt, an edge interrupt and a rotating interrupt side by side, with two of them sharing a core, and to watch the masked and unmasked behaviour of one while the others stay active.

// File: rtl/cid_pkg.sv
package cid_pkg;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_SET_DEST  = 4'd1,
    OP_SET_MODE  = 4'd2,
    OP_READ_MODE = 4'd3,
    OP_SET_MASK  = 4'd4,
    OP_ACK       = 4'd5,
    OP_ENABLE    = 4'd6,
    OP_READ_DEST = 4'd7
  } cidOp_e;

  localparam logic [1:0] DISTR_DIRECT = 2'd0;
  localparam logic [1:0] DISTR_RR     = 2'd1;
  localparam int         TRIG_BIT     = 4;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic wrDest;
    logic wrMode;
    logic wrMask;
    logic ack;
    logic rdMode;
    logic rdDest;
  } cidStrobe_t;

endpackage

// File: rtl/cid_ctrl.sv
module cid_ctrl
  import cid_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [3:0] cmdOp,
  output cidStrobe_t strb,
  output logic       deliverEn
);

  cidOp_e opc;
  assign opc = cidOp_e'(cmdOp);

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      case (opc)
        OP_SET_DEST:  strb.wrDest = 1'b1;
        OP_SET_MODE:  strb.wrMode = 1'b1;
        OP_SET_MASK:  strb.wrMask = 1'b1;
        OP_ACK:       strb.ack    = 1'b1;
        OP_READ_MODE: strb.rdMode = 1'b1;
        OP_READ_DEST: strb.rdDest = 1'b1;
        default: ;
      endcase
    end
  end

  // global delivery switch, set once by the enable command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            deliverEn <= 1'b0;
    else if (cmdValid && opc == OP_ENABLE) deliverEn <= 1'b1;
  end

endmodule

// File: rtl/cid_datapath.sv
module cid_datapath
  import cid_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_CORE = 4,
  parameter int IDX_W    = 2,
  localparam int PW      = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  cidStrobe_t                         strb,
  input  logic                               deliverEn,
  input  logic [IDX_W-1:0]                   cmdIdx,
  input  logic [31:0]                        cmdData,
  input  logic [NUM_IRQ-1:0]                 irqIn,
  output logic [NUM_CORE-1:0]                coreIrq,
  output logic [31:0]                        readback,
  output logic [NUM_IRQ-1:0][NUM_CORE-1:0]   routeVec,
  output logic [NUM_IRQ-1:0][NUM_CORE-1:0]   destVec,
  output logic [NUM_IRQ-1:0]                 rrModeVec,
  output logic [NUM_IRQ-1:0]                 maskVec
);

  logic [NUM_IRQ-1:0][31:0] modeWord;

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : gIrq
    logic                hit;
    logic [NUM_CORE-1:0] destQ;
    logic [1:0]          distrQ;
    logic                trigQ, maskQ, pendQ, syncQ;
    logic [PW-1:0]       ptrQ, selIdx, ptrNext, cand;
    logic                selFound, active, rrMode;

    assign hit    = (cmdIdx == IDX_W'(gi));
    assign rrMode = (distrQ == DISTR_RR);
    assign active = trigQ ? pendQ : syncQ;

    // first destination core at or after the pointer, wrapping
    always_comb begin
      selIdx   = '0;
      selFound = 1'b0;
      cand     = '0;
      for (int k = NUM_CORE - 1; k >= 0; k--) begin
        cand = PW'((int'(ptrQ) + k) % NUM_CORE);
        if (destQ[cand]) begin
          selIdx   = cand;
          selFound = 1'b1;
        end
      end
      ptrNext = PW'((int'(selIdx) + 1) % NUM_CORE);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        destQ  <= '0;
        distrQ <= DISTR_DIRECT;
        trigQ  <= 1'b0;
        maskQ  <= 1'b1;
        pendQ  <= 1'b0;
        syncQ  <= 1'b0;
        ptrQ   <= '0;
      end else begin
        syncQ <= irqIn[gi];
        if (irqIn[gi] && !syncQ)  pendQ <= 1'b1;
        else if (strb.ack && hit) pendQ <= 1'b0;
        if (strb.wrDest && hit) destQ <= cmdData[NUM_CORE-1:0];
        if (strb.wrMode && hit) begin
          distrQ <= cmdData[1:0];
          trigQ  <= cmdData[TRIG_BIT];
        end
        if (strb.wrMask && hit) maskQ <= cmdData[0];
        if (strb.ack && hit && rrMode && selFound) ptrQ <= ptrNext;
      end
    end

    always_comb begin
      routeVec[gi] = '0;
      if (active && !maskQ && deliverEn) begin
        if (rrMode) routeVec[gi] = {NUM_CORE{selFound}} & (NUM_CORE'(1) << selIdx);
        else        routeVec[gi] = destQ;
      end
    end

    assign modeWord[gi]  = {27'd0, trigQ, 2'b00, distrQ};
    assign destVec[gi]   = destQ;
    assign rrModeVec[gi] = rrMode;
    assign maskVec[gi]   = maskQ;
  end

  always_comb begin
    coreIrq = '0;
    for (int i = 0; i < NUM_IRQ; i++) coreIrq = coreIrq | routeVec[i];
  end

  logic idxOk;
  assign idxOk = (int'(cmdIdx) < NUM_IRQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            readback <= '0;
    else if (strb.rdMode) readback <= idxOk ? modeWord[cmdIdx] : '0;
    else if (strb.rdDest) readback <= idxOk ? 32'(destVec[cmdIdx]) : '0;
  end

endmodule

// File: rtl/common_irq_distributor.sv
module common_irq_distributor
  import cid_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_CORE = 4,
  localparam int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [3:0]           cmdOp,
  input  logic [IDX_W-1:0]     cmdIdx,
  input  logic [31:0]          cmdData,
  output logic [31:0]          readback,
  input  logic [NUM_IRQ-1:0]   irqIn,
  output logic [NUM_CORE-1:0]  coreIrq
);

  cidStrobe_t                        strb;
  logic                              deliverEn;
  logic [NUM_IRQ-1:0][NUM_CORE-1:0]  routeVec, destVec;
  logic [NUM_IRQ-1:0]                rrModeVec, maskVec;

  cid_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .strb      (strb),
    .deliverEn (deliverEn)
  );

  cid_datapath #(
    .NUM_IRQ  (NUM_IRQ),
    .NUM_CORE (NUM_CORE),
    .IDX_W    (IDX_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .deliverEn (deliverEn),
    .cmdIdx    (cmdIdx),
    .cmdData   (cmdData),
    .irqIn     (irqIn),
    .coreIrq   (coreIrq),
    .readback  (readback),
    .routeVec  (routeVec),
    .destVec   (destVec),
    .rrModeVec (rrModeVec),
    .maskVec   (maskVec)
  );

endmodule

// File: rtl/cid_checker.sv
module cid_checker #(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_CORE = 4
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               cmdValid,
  input logic [3:0]                         cmdOp,
  input logic [31:0]                        readback,
  input logic [NUM_CORE-1:0]                coreIrq,
  input logic [NUM_IRQ-1:0][NUM_CORE-1:0]   routeVec,
  input logic [NUM_IRQ-1:0][NUM_CORE-1:0]   destVec,
  input logic [NUM_IRQ-1:0]                 rrModeVec,
  input logic [NUM_IRQ-1:0]                 maskVec
);

  logic seenEn;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               seenEn <= 1'b0;
    else if (cmdValid && cmdOp == 4'd6)      seenEn <= 1'b1;
  end

  logic rdCmd, rdModeCmd;
  assign rdModeCmd = cmdValid && (cmdOp == 4'd3);
  assign rdCmd     = rdModeCmd || (cmdValid && (cmdOp == 4'd7));

  assert_quiet_until_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !seenEn |-> (coreIrq == '0));

  assert_mode_pad_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdModeCmd) |-> (readback[31:5] == '0 && readback[3:2] == '0));

  assert_readback_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdCmd) |-> $stable(readback));

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : gChk
    assert_route_in_dest_R5: assert property (@(posedge clk) disable iff (!rstN)
      (routeVec[gi] & ~destVec[gi]) == '0);
    assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
      maskVec[gi] |-> (routeVec[gi] == '0));
    assert_rr_single_core_R9: assert property (@(posedge clk) disable iff (!rstN)
      rrModeVec[gi] |-> $onehot0(routeVec[gi]));
  end

endmodule

bind common_irq_distributor cid_checker #(
  .NUM_IRQ  (NUM_IRQ),
  .NUM_CORE (NUM_CORE)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdOp     (cmdOp),
  .readback  (readback),
  .coreIrq   (coreIrq),
  .routeVec  (routeVec),
  .destVec   (destVec),
  .rrModeVec (rrModeVec),
  .maskVec   (maskVec)
);

// File: tb/tb_common_irq_distributor.sv
`timescale 1ns/1ps
module tb_common_irq_distributor;

  localparam int NI = 4;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = '0;
  logic [1:0]  cmdIdx = '0;
  logic [31:0] cmdData = '0;
  logic [31:0] readback;
  logic [NI-1:0] irqIn = '0;
  logic [NC-1:0] coreIrq;

  always #10 clk = ~clk;

  common_irq_distributor #(.NUM_IRQ(NI), .NUM_CORE(NC)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIdx(cmdIdx), .cmdData(cmdData), .readback(readback),
    .irqIn(irqIn), .coreIrq(coreIrq)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  idx;
    logic [31:0] data;
    logic [3:0]  irq;
    logic [3:0]  expCore;
    logic        chkRb;
    logic [31:0] expRb;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 2'd0, 32'h0,        4'h0, 4'h0, 1'b1, 32'h0,  8'd1},  // R1 mode reset
    '{4'd7, 2'd0, 32'h0,        4'h0, 4'h0, 1'b1, 32'h0,  8'd1},  // R1 dest reset
    '{4'd1, 2'd0, 32'h3,        4'h0, 4'h0, 1'b0, 32'h0,  8'd2},  // R2 set dest
    '{4'd7, 2'd0, 32'h0,        4'h0, 4'h0, 1'b1, 32'h3,  8'd2},  // R2 read dest
    '{4'd2, 2'd0, 32'hFFFFFFFF, 4'h0, 4'h0, 1'b0, 32'h0,  8'd3},  // R3 write ones
    '{4'd3, 2'd0, 32'h0,        4'h0, 4'h0, 1'b1, 32'h13, 8'd3},  // R3 packed read
    '{4'd2, 2'd0, 32'h0,        4'h0, 4'h0, 1'b0, 32'h0,  8'd3},  // R3 direct/level
    '{4'd3, 2'd0, 32'h0,        4'h0, 4'h0, 1'b1, 32'h0,  8'd3},  // R3
    '{4'd4, 2'd0, 32'h0,        4'h1, 4'h0, 1'b0, 32'h0,  8'd4},  // R4 unmasked, not enabled
    '{4'd0, 2'd0, 32'h0,        4'h1, 4'h0, 1'b0, 32'h0,  8'd4},  // R4
    '{4'd6, 2'd0, 32'h0,        4'h1, 4'h3, 1'b0, 32'h0,  8'd5},  // R5 direct to 0,1
    '{4'd0, 2'd0, 32'h0,        4'h0, 4'h0, 1'b0, 32'h0,  8'd6},  // R6 level drop
    '{4'd0, 2'd0, 32'h0,        4'h1, 4'h3, 1'b0, 32'h0,  8'd6},  // R6 level high
    '{4'd1, 2'd1, 32'h4,        4'h0, 4'h0, 1'b0, 32'h0,  8'd7},  // R7 setup
    '{4'd2, 2'd1, 32'h10,       4'h0, 4'h0, 1'b0, 32'h0,  8'd7},  // R7 edge direct
    '{4'd4, 2'd1, 32'h0,        4'h0, 4'h0, 1'b0, 32'h0,  8'd7},  // R7 unmask
    '{4'd0, 2'd0, 32'h0,        4'h2, 4'h4, 1'b0, 32'h0,  8'd7},  // R7 rising edge
    '{4'd0, 2'd0, 32'h0,        4'h0, 4'h4, 1'b0, 32'h0,  8'd7},  // R7 held after fall
    '{4'd4, 2'd1, 32'h1,        4'h0, 4'h0, 1'b0, 32'h0,  8'd8},  // R8 masked
    '{4'd4, 2'd1, 32'h0,        4'h0, 4'h4, 1'b0, 32'h0,  8'd8},  // R8 latch kept
    '{4'd5, 2'd1, 32'h0,        4'h0, 4'h0, 1'b0, 32'h0,  8'd7},  // R7 ack clears
    '{4'd0, 2'd0, 32'h0,        4'h3, 4'h7, 1'b0, 32'h0,  8'd11}, // R11 OR of two
    '{4'd5, 2'd1, 32'h0,        4'h1, 4'h3, 1'b0, 32'h0,  8'd11}, // R11 one left
    '{4'd0, 2'd0, 32'h0,        4'h0, 4'h0, 1'b0, 32'h0,  8'd6},  // R6
    '{4'd1, 2'd2, 32'hB,        4'h0, 4'h0, 1'b0, 32'h0,  8'd9},  // R9 dest {0,1,3}
    '{4'd2, 2'd2, 32'h11,       4'h0, 4'h0, 1'b0, 32'h0,  8'd9},  // R9 rr edge
    '{4'd3, 2'd2, 32'h0,        4'h0, 4'h0, 1'b1, 32'h11, 8'd3},  // R3
    '{4'd4, 2'd2, 32'h0,        4'h0, 4'h0, 1'b0, 32'h0,  8'd9},  // R9 unmask
    '{4'd0, 2'd0, 32'h0,        4'h4, 4'h1, 1'b0, 32'h0,  8'd9},  // R9 core0
    '{4'd0, 2'd0, 32'h0,        4'h0, 4'h1, 1'b0, 32'h0,  8'd10}, // R10 fixed
    '{4'd5, 2'd2, 32'h0,        4'h0, 4'h0, 1'b0, 32'h0,  8'd9},  // R9 ack
    '{4'd0, 2'd0, 32'h0,        4'h4, 4'h2, 1'b0, 32'h0,  8'd9},  // R9 core1
    '{4'd0, 2'd0, 32'h0,        4'h0, 4'h2, 1'b0, 32'h0,  8'd10}, // R10
    '{4'd5, 2'd2, 32'h0,        4'h0, 4'h0, 1'b0, 32'h0,  8'd9},  // R9
    '{4'd0, 2'd0, 32'h0,        4'h4, 4'h8, 1'b0, 32'h0,  8'd9},  // R9 skip core2
    '{4'd5, 2'd2, 32'h0,        4'h0, 4'h0, 1'b0, 32'h0,  8'd9},  // R9
    '{4'd0, 2'd0, 32'h0,        4'h4, 4'h1, 1'b0, 32'h0,  8'd9},  // R9 wrap to core0
    '{4'd5, 2'd2, 32'h0,        4'h0, 4'h0, 1'b0, 32'h0,  8'd9},  // R9
    '{4'd5, 2'd0, 32'h0,        4'h1, 4'h3, 1'b0, 32'h0,  8'd6}   // R6 ack no effect
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic checkCore(input logic [3:0] exp, input int req);
    checks++;
    if (coreIrq !== exp) begin
      fails++;
      $display("FAIL R%0d: coreIrq=%h expected %h", req, coreIrq, exp);
    end
  endtask

  task automatic checkRb(input logic [31:0] exp, input int req);
    checks++;
    if (readback !== exp) begin
      fails++;
      $display("FAIL R%0d: readback=%h expected %h", req, readback, exp);
    end
  endtask

  // drive at negedge, let one edge accept it, sample at the next negedge
  task automatic step(input logic [3:0] op, input logic [1:0] idx,
                      input logic [31:0] data, input logic [3:0] irq);
    cmdValid = (op != 4'd0);
    cmdOp    = op;
    cmdIdx   = idx;
    cmdData  = data;
    irqIn    = irq;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkCore(4'h0, 1);    // R1 outputs low
    checkRb(32'h0, 1);     // R1 readback zero

    for (int v = 0; v < NV; v++) begin
      step(VECS[v].op, VECS[v].idx, VECS[v].data, VECS[v].irq);
      checkCore(VECS[v].expCore, int'(VECS[v].req));
      if (VECS[v].chkRb) checkRb(VECS[v].expRb, int'(VECS[v].req));
    end

    // R1: reset in mid-run restores masks and disables delivery
    irqIn = '0;
    rstN  = 1'b0;
    @(negedge clk);
    checkCore(4'h0, 1);
    rstN = 1'b1;
    step(4'd6, 2'd0, 32'h0, 4'h0);
    step(4'd1, 2'd0, 32'hF, 4'h1);
    checkCore(4'h0, 1);    // R1 masked after reset
    step(4'd4, 2'd0, 32'h0, 4'h1);
    checkCore(4'hF, 5);    // R5 direct to all four
    step(4'd3, 2'd0, 32'h0, 4'h1);
    checkRb(32'h0, 1);     // R1 mode word cleared

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule